// File: doc/BRIEF.md
# Deferred Exception Tag Writeback Unit

This block sits at the writeback end of a simple in-order datapath and holds the register file. Every register carries a one-bit exception mark beside its data word. An instruction that was hoisted above a branch is flagged speculative. When such an instruction faults, the trap is not taken. Instead, the instruction's own program counter goes into the destination data word and the destination is marked. Any later speculative instruction that reads a marked register passes both the mark and the stored program counter on to its own destination.

The trap is raised only when a non-speculative instruction consumes a marked register, or faults itself. The report carries the program counter of the instruction that first caused the fault. A separate restore port writes a data word and its mark together, so that context-switch code can put the state back.

The block presents the source operands it reads from the register file, the writeback word and mark, and a write-commit flag. The trap report is registered, so it appears in the cycle after the instruction that raises it.

Top module: `spec_tag_wb`

## Requirements
- R1: After reset, every register reads data 0 with its mark clear, and `trap_valid` is low.
- R2: A speculative instruction with no marked used source and no fault writes `fu_result` with the mark clear. A speculative instruction never raises a trap.
- R3: A speculative instruction with no marked used source that faults writes the mark set and `issue_pc` as data.
- R4: A speculative instruction with a marked used source writes the mark set and copies that source's data word. This takes precedence over its own fault.
- R5: When both used sources are marked, source 1's data word is the one forwarded or reported.
- R6: A non-speculative instruction that faults with no marked used source raises `trap_valid` for one cycle in the next cycle, with `trap_pc` equal to its own `issue_pc`. It writes nothing.
- R7: A non-speculative instruction with a marked used source raises `trap_valid` in the next cycle, with `trap_pc` equal to that source's data word. It writes nothing.
- R8: A non-speculative instruction with no marked used source and no fault writes `fu_result` with the mark clear and raises no trap.
- R9: Register 0 always reads data 0 with the mark clear. Writes to it, from either port, are ignored and `wb_commit` stays low.
- R10: The restore port writes its data and mark into the addressed register at the clock edge. When it targets the same register as a writeback in the same cycle, the restore value is kept.
- R11: A source whose `srcN_used` input is low has no effect, even when its register is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is in writeback this cycle |
| issue_spec | input | 1 | Speculative flag from the opcode |
| issue_pc | input | DATA_W | Program counter of the instruction |
| src1_idx | input | IDX_W | Source 1 register number |
| src1_used | input | 1 | Source 1 is an operand of the instruction |
| src2_idx | input | IDX_W | Source 2 register number |
| src2_used | input | 1 | Source 2 is an operand of the instruction |
| dst_idx | input | IDX_W | Destination register number |
| dst_we | input | 1 | The instruction writes a destination |
| fu_result | input | DATA_W | Result computed by the functional unit |
| fu_fault | input | 1 | Raw exception from the functional unit |
| ctx_we | input | 1 | Restore port write enable |
| ctx_idx | input | IDX_W | Restore port register number |
| ctx_data | input | DATA_W | Restore port data word |
| ctx_tag | input | 1 | Restore port mark |
| src1_data | output | DATA_W | Data word of register `src1_idx` |
| src1_tag | output | 1 | Mark of register `src1_idx` |
| src2_data | output | DATA_W | Data word of register `src2_idx` |
| src2_tag | output | 1 | Mark of register `src2_idx` |
| wb_commit | output | 1 | The destination is written at this clock edge |
| wb_tag | output | 1 | Mark to be written |
| wb_data | output | DATA_W | Data word to be written |
| trap_valid | output | 1 | Precise exception report |
| trap_pc | output | DATA_W | Program counter of the faulting instruction |

## Verification
The bench builds the block with 16-bit data, eight registers and a registered trap output. Random register numbers therefore often collide: the same register is a source, a destination, a restore target and register 0 within a short run. Marks also spread through chains of dependent speculative instructions. The narrow data word still holds distinct random program counters, so a forwarded value can be told apart from a local one.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;

   // How the writeback word is formed
   typedef enum logic [1:0] {
      WB_CLEAN     = 2'd0,
      WB_OWN_FAULT = 2'd1,
      WB_FORWARD   = 2'd2
   } wb_kind_e;

   function automatic wb_kind_e pick_kind(input logic any_marked, input logic fault);
      if (any_marked)
         return WB_FORWARD;
      else if (fault)
         return WB_OWN_FAULT;
      else
         return WB_CLEAN;
   endfunction

endpackage

// File: rtl/spec_tag_regfile.sv
module spec_tag_regfile #(
   parameter int DATA_W = 32,
   parameter int NREGS  = 16,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd1_idx,
   output logic [DATA_W-1:0] rd1_data,
   output logic              rd1_tag,
   input  logic [IDX_W-1:0]  rd2_idx,
   output logic [DATA_W-1:0] rd2_data,
   output logic              rd2_tag,
   input  logic              wb_we,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              wb_tag,
   input  logic              ctx_we,
   input  logic [IDX_W-1:0]  ctx_idx,
   input  logic [DATA_W-1:0] ctx_data,
   input  logic              ctx_tag
);

   logic [DATA_W-1:0] data_q [NREGS];
   logic              tag_q  [NREGS];

   assign data_q[0] = '0;
   assign tag_q[0]  = 1'b0;

   for (genvar r = 1; r < NREGS; r++) begin : g_reg
      logic hit_ctx, hit_wb;
      assign hit_ctx = ctx_we && (ctx_idx == IDX_W'(r));
      assign hit_wb  = wb_we  && (wb_idx  == IDX_W'(r));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[r] <= '0;
            tag_q[r]  <= 1'b0;
         end else if (hit_ctx) begin
            data_q[r] <= ctx_data;
            tag_q[r]  <= ctx_tag;
         end else if (hit_wb) begin
            data_q[r] <= wb_data;
            tag_q[r]  <= wb_tag;
         end
      end
   end

   assign rd1_data = data_q[rd1_idx];
   assign rd1_tag  = tag_q[rd1_idx];
   assign rd2_data = data_q[rd2_idx];
   assign rd2_tag  = tag_q[rd2_idx];

endmodule

// File: rtl/spec_tag_resolve.sv
module spec_tag_resolve
   import spec_tag_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              valid,
   input  logic              spec,
   input  logic [DATA_W-1:0] pc,
   input  logic              s1_used,
   input  logic              s1_tag,
   input  logic [DATA_W-1:0] s1_data,
   input  logic              s2_used,
   input  logic              s2_tag,
   input  logic [DATA_W-1:0] s2_data,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic              dst_we,
   input  logic [DATA_W-1:0] result,
   input  logic              fault,
   output logic              commit,
   output logic              out_tag,
   output logic [DATA_W-1:0] out_data,
   output logic              trap_now,
   output logic [DATA_W-1:0] trap_pc_now
);

   logic              m1, m2, any_marked;
   logic [DATA_W-1:0] carried;
   wb_kind_e          kind;

   assign m1         = s1_used && s1_tag;
   assign m2         = s2_used && s2_tag;
   assign any_marked = m1 || m2;
   assign carried    = m1 ? s1_data : s2_data;   // source 1 first
   assign kind       = pick_kind(any_marked, fault);

   always_comb begin
      out_tag     = 1'b0;
      out_data    = result;
      trap_now    = 1'b0;
      trap_pc_now = '0;
      unique case (kind)
         WB_FORWARD: begin
            out_tag     = 1'b1;
            out_data    = carried;
            trap_pc_now = carried;
         end
         WB_OWN_FAULT: begin
            out_tag     = 1'b1;
            out_data    = pc;
            trap_pc_now = pc;
         end
         default: ;
      endcase
      trap_now = valid && !spec && (kind != WB_CLEAN);
   end

   assign commit = valid && dst_we && (dst_idx != '0) && !trap_now;

endmodule

// File: rtl/spec_tag_trap_out.sv
module spec_tag_trap_out #(
   parameter int DATA_W   = 32,
   parameter bit REG_TRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_now,
   input  logic [DATA_W-1:0] trap_pc_now,
   output logic              trap_valid,
   output logic [DATA_W-1:0] trap_pc
);

   if (REG_TRAP) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_pc    <= '0;
         end else begin
            trap_valid <= trap_now;
            trap_pc    <= trap_now ? trap_pc_now : '0;
         end
      end
   end else begin : g_comb
      assign trap_valid = trap_now;
      assign trap_pc    = trap_now ? trap_pc_now : '0;
   end

endmodule

// File: rtl/spec_tag_wb.sv
module spec_tag_wb #(
   parameter int  DATA_W   = 32,
   parameter int  NREGS    = 16,
   parameter bit  REG_TRAP = 1'b1,
   localparam int IDX_W    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic              issue_spec,
   input  logic [DATA_W-1:0] issue_pc,
   input  logic [IDX_W-1:0]  src1_idx,
   input  logic              src1_used,
   input  logic [IDX_W-1:0]  src2_idx,
   input  logic              src2_used,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic              dst_we,
   input  logic [DATA_W-1:0] fu_result,
   input  logic              fu_fault,
   input  logic              ctx_we,
   input  logic [IDX_W-1:0]  ctx_idx,
   input  logic [DATA_W-1:0] ctx_data,
   input  logic              ctx_tag,
   output logic [DATA_W-1:0] src1_data,
   output logic              src1_tag,
   output logic [DATA_W-1:0] src2_data,
   output logic              src2_tag,
   output logic              wb_commit,
   output logic              wb_tag,
   output logic [DATA_W-1:0] wb_data,
   output logic              trap_valid,
   output logic [DATA_W-1:0] trap_pc
);

   if (NREGS < 2 || (1 << IDX_W) != NREGS) begin : g_bad_nregs
      $error("spec_tag_wb: NREGS must be a power of two of at least 2");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("spec_tag_wb: DATA_W must be at least 8");
   end

   logic              trap_now;
   logic [DATA_W-1:0] trap_pc_now;

   spec_tag_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) i_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd1_idx  (src1_idx),
      .rd1_data (src1_data),
      .rd1_tag  (src1_tag),
      .rd2_idx  (src2_idx),
      .rd2_data (src2_data),
      .rd2_tag  (src2_tag),
      .wb_we    (wb_commit),
      .wb_idx   (dst_idx),
      .wb_data  (wb_data),
      .wb_tag   (wb_tag),
      .ctx_we   (ctx_we),
      .ctx_idx  (ctx_idx),
      .ctx_data (ctx_data),
      .ctx_tag  (ctx_tag)
   );

   spec_tag_resolve #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_res (
      .valid       (issue_valid),
      .spec        (issue_spec),
      .pc          (issue_pc),
      .s1_used     (src1_used),
      .s1_tag      (src1_tag),
      .s1_data     (src1_data),
      .s2_used     (src2_used),
      .s2_tag      (src2_tag),
      .s2_data     (src2_data),
      .dst_idx     (dst_idx),
      .dst_we      (dst_we),
      .result      (fu_result),
      .fault       (fu_fault),
      .commit      (wb_commit),
      .out_tag     (wb_tag),
      .out_data    (wb_data),
      .trap_now    (trap_now),
      .trap_pc_now (trap_pc_now)
   );

   spec_tag_trap_out #(.DATA_W(DATA_W), .REG_TRAP(REG_TRAP)) i_trap (
      .clk         (clk),
      .rst_n       (rst_n),
      .trap_now    (trap_now),
      .trap_pc_now (trap_pc_now),
      .trap_valid  (trap_valid),
      .trap_pc     (trap_pc)
   );

endmodule

// File: rtl/spec_tag_chk.sv
module spec_tag_chk #(
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 4,
   parameter bit REG_TRAP = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic              issue_spec,
   input logic [DATA_W-1:0] issue_pc,
   input logic [IDX_W-1:0]  src1_idx,
   input logic              src1_used,
   input logic              src2_used,
   input logic [DATA_W-1:0] fu_result,
   input logic              fu_fault,
   input logic [DATA_W-1:0] src1_data,
   input logic              src1_tag,
   input logic [DATA_W-1:0] src2_data,
   input logic              src2_tag,
   input logic              wb_tag,
   input logic [DATA_W-1:0] wb_data,
   input logic              trap_valid,
   input logic [DATA_W-1:0] trap_pc
);

   logic clean_src;
   assign clean_src = !(src1_used && src1_tag) && !(src2_used && src2_tag);

   // R2
   spec_clean_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_spec && clean_src && !fu_fault |-> !wb_tag && wb_data == fu_result);

   // R2
   spec_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      REG_TRAP && issue_valid && issue_spec |=> !trap_valid);

   // R3
   spec_own_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_spec && clean_src && fu_fault |-> wb_tag && wb_data == issue_pc);

   // R5
   src1_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_spec && src1_used && src1_tag |-> wb_tag && wb_data == src1_data);

   // R6
   own_fault_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      REG_TRAP && issue_valid && !issue_spec && clean_src && fu_fault
      |=> trap_valid && trap_pc == $past(issue_pc));

   // R9
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src1_idx == '0 |-> src1_data == '0 && !src1_tag);

endmodule

bind spec_tag_wb spec_tag_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .REG_TRAP(REG_TRAP)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_spec  (issue_spec),
   .issue_pc    (issue_pc),
   .src1_idx    (src1_idx),
   .src1_used   (src1_used),
   .src2_used   (src2_used),
   .fu_result   (fu_result),
   .fu_fault    (fu_fault),
   .src1_data   (src1_data),
   .src1_tag    (src1_tag),
   .src2_data   (src2_data),
   .src2_tag    (src2_tag),
   .wb_tag      (wb_tag),
   .wb_data     (wb_data),
   .trap_valid  (trap_valid),
   .trap_pc     (trap_pc)
);

// File: tb/test_spec_tag_wb.sv
`timescale 1ns/1ps
module test_spec_tag_wb;

   localparam int DW = 16;
   localparam int NR = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_valid = 0, issue_spec = 0, src1_used = 0, src2_used = 0;
   logic dst_we = 0, fu_fault = 0, ctx_we = 0, ctx_tag = 0;
   logic [DW-1:0] issue_pc = '0, fu_result = '0, ctx_data = '0;
   logic [IW-1:0] src1_idx = '0, src2_idx = '0, dst_idx = '0, ctx_idx = '0;
   logic [DW-1:0] src1_data, src2_data, wb_data, trap_pc;
   logic src1_tag, src2_tag, wb_commit, wb_tag, trap_valid;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] md [NR];
   logic          mt [NR];

   always #4 clk = ~clk;

   spec_tag_wb #(.DATA_W(DW), .NREGS(NR), .REG_TRAP(1'b1)) i_spec_tag_wb (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_spec(issue_spec),
      .issue_pc(issue_pc), .src1_idx(src1_idx), .src1_used(src1_used),
      .src2_idx(src2_idx), .src2_used(src2_used), .dst_idx(dst_idx), .dst_we(dst_we),
      .fu_result(fu_result), .fu_fault(fu_fault), .ctx_we(ctx_we), .ctx_idx(ctx_idx),
      .ctx_data(ctx_data), .ctx_tag(ctx_tag), .src1_data(src1_data), .src1_tag(src1_tag),
      .src2_data(src2_data), .src2_tag(src2_tag), .wb_commit(wb_commit), .wb_tag(wb_tag),
      .wb_data(wb_data), .trap_valid(trap_valid), .trap_pc(trap_pc));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // One instruction, optionally with a restore write in the same cycle
   task automatic run_op(input bit spec, input logic [IW-1:0] s1, input bit u1,
                         input logic [IW-1:0] s2, input bit u2, input logic [IW-1:0] d,
                         input bit we, input bit fault, input logic [DW-1:0] pc,
                         input logic [DW-1:0] res, input bit cw, input logic [IW-1:0] ci,
                         input logic [DW-1:0] cd, input bit ct);
      bit m1, m2, any, e_commit, e_tag, e_trap;
      logic [DW-1:0] e_data;
      string req;
      @(negedge clk);
      issue_valid = 1; issue_spec = spec; src1_idx = s1; src1_used = u1;
      src2_idx = s2; src2_used = u2; dst_idx = d; dst_we = we; fu_fault = fault;
      issue_pc = pc; fu_result = res; ctx_we = cw; ctx_idx = ci; ctx_data = cd; ctx_tag = ct;
      #1;
      m1 = u1 && mt[s1];
      m2 = u2 && mt[s2];
      any = m1 || m2;
      if (m1 && m2) req = "R5";
      else if (any) req = spec ? "R4" : "R7";
      else if (fault) req = spec ? "R3" : "R6";
      else if ((!u1 && mt[s1]) || (!u2 && mt[s2])) req = "R11";
      else req = spec ? "R2" : "R8";
      e_tag  = any || fault;
      e_data = m1 ? md[s1] : (m2 ? md[s2] : (fault ? pc : res));
      e_trap = !spec && e_tag;
      e_commit = we && (d != 0) && !e_trap;
      chk(src1_data == md[s1] && src1_tag == mt[s1], (s1 == 0) ? "R9" : "R10",
          {src1_tag, src1_data}, {mt[s1], md[s1]});
      chk(wb_commit == e_commit, (we && d == 0) ? "R9" : req, wb_commit, e_commit);
      if (e_commit)
         chk(wb_tag == e_tag && wb_data == e_data, req, {wb_tag, wb_data}, {e_tag, e_data});
      @(negedge clk);
      chk(trap_valid == e_trap, req, trap_valid, e_trap);
      if (e_trap) chk(trap_pc == e_data, req, trap_pc, e_data);
      if (cw && ci != 0) begin md[ci] = cd; mt[ci] = ct; end
      if (e_commit && !(cw && ci == d)) begin md[d] = e_data; mt[d] = e_tag; end
      issue_valid = 0; ctx_we = 0;
      @(negedge clk);
      chk(trap_valid == 1'b0, "R6", trap_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < NR; i++) begin md[i] = '0; mt[i] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int i = 0; i < NR; i++) begin
         src1_idx = IW'(i); #1;
         chk(src1_data == '0 && src1_tag == 1'b0, "R1", {src1_tag, src1_data}, 0);
      end
      chk(trap_valid == 1'b0, "R1", trap_valid, 0);

      // R2 speculative clean
      run_op(1, 1, 1, 2, 1, 1, 1, 0, 16'h0100, 16'hBEEF, 0, 0, 0, 0);
      // R3 speculative fault marks r3 with its PC
      run_op(1, 1, 1, 2, 1, 3, 1, 1, 16'h1234, 16'h5555, 0, 0, 0, 0);
      // R4 chain r3 -> r4
      run_op(1, 3, 1, 0, 0, 4, 1, 1, 16'h2000, 16'h6666, 0, 0, 0, 0);
      // R7 non-speculative consumer of r4 reports 0x1234
      run_op(0, 2, 1, 4, 1, 5, 1, 0, 16'h3000, 16'h7777, 0, 0, 0, 0);
      // R5 both marked: restore r6 with other PC, read r6 and r3
      run_op(0, 0, 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1, 6, 16'hABCD, 1);
      run_op(1, 6, 1, 3, 1, 7, 1, 0, 16'h3100, 16'h1111, 0, 0, 0, 0);
      run_op(0, 3, 1, 6, 1, 7, 1, 0, 16'h3200, 16'h1111, 0, 0, 0, 0);
      // R11 unused marked source
      run_op(0, 3, 0, 6, 0, 2, 1, 0, 16'h3300, 16'h4242, 0, 0, 0, 0);
      // R6 non-speculative own fault
      run_op(0, 1, 1, 2, 1, 5, 1, 1, 16'h4000, 16'h9999, 0, 0, 0, 0);
      // R8 non-speculative clean
      run_op(0, 1, 1, 2, 1, 5, 1, 0, 16'h4100, 16'h0F0F, 0, 0, 0, 0);
      // R9 writes to register 0 from both ports
      run_op(1, 3, 1, 0, 0, 0, 1, 0, 16'h5000, 16'hFFFF, 1, 0, 16'hAAAA, 1);
      // R10 restore and writeback collide on r5
      run_op(1, 1, 1, 2, 1, 5, 1, 0, 16'h6000, 16'h1357, 1, 5, 16'h2468, 1);

      // constrained random
      for (int n = 0; n < 400; n++) begin
         bit cw;
         cw = ($urandom % 5) == 0;
         run_op(1'($urandom), IW'($urandom), 1'($urandom % 4 != 0), IW'($urandom),
                1'($urandom % 4 != 0), IW'($urandom), 1'($urandom % 8 != 0),
                1'($urandom % 4 == 0), DW'($urandom), DW'($urandom),
                cw, IW'($urandom), DW'($urandom), 1'($urandom));
      end
      finish_run();
   end

endmodule